// File: doc/BRIEF.md
# Mode-Selected Sampling Clock Generator

This block produces the bit-rate data clocks for the encoder and decoder halves of a delta-modulation codec. It runs on the 1.024 MHz reference, which serves as its system clock, and a two-bit rate selector sets its mode. In the three internal modes it divides the reference by 16, 32 or 64 to give 64, 32 or 16 kbit/s. It drives that one clock out on both data-clock ports with their output enables asserted, so that outside circuits can lock to it.

In external mode both output enables drop, so each port carries a clock supplied from outside. The encoder and decoder clocks may be separate or the same. Each is resynchronised into the reference domain and passed on to its codec core as a level. For every data bit the block also gives each core a one-cycle strobe.

Top module: `sclk_gen`

## Requirements
- R1: While rst_ni is low, both pad clock outputs, both core clocks and both strobes are 0.
- R2: mode_i selects the rate: 2'b00 external, 2'b01 a period of 16 reference cycles, 2'b10 a period of 32, 2'b11 a period of 64.
- R3: In an internal mode the generated clock is high for exactly half its period and low for the other half.
- R4: In an internal mode enc_clk_o and dec_clk_o carry the identical waveform.
- R5: enc_clk_oe_o and dec_clk_oe_o are 1 exactly when mode_i is not 2'b00.
- R6: A change of mode_i restarts the divider. The generated clock is low for the first half period after the change and rises on the (half+1)-th reference edge, counting the edge that first sees the new mode as edge 1.
- R7: In an internal mode each strobe is high for exactly one cycle per period. That cycle is the first cycle of the high phase.
- R8: In external mode both pad clock outputs stay 0, and each strobe is 1 for one cycle per rising edge of its own external clock input.
- R9: In external mode each core clock follows its own external clock input two reference edges later. A strobe is high in the cycle where that delayed level first reads 1.
- R10: In an internal mode the external clock inputs have no effect. The core clocks equal the generated clock, and strobes come only from the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1.024 MHz reference, system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Rate and direction selector |
| enc_clk_i | input | 1 | Encoder clock from pad (external mode) |
| dec_clk_i | input | 1 | Decoder clock from pad (external mode) |
| enc_clk_o | output | 1 | Encoder clock pad drive |
| dec_clk_o | output | 1 | Decoder clock pad drive |
| enc_clk_oe_o | output | 1 | Encoder clock pad output enable |
| dec_clk_oe_o | output | 1 | Decoder clock pad output enable |
| enc_core_clk_o | output | 1 | Encoder bit clock to the codec core |
| dec_core_clk_o | output | 1 | Decoder bit clock to the codec core |
| enc_strobe_o | output | 1 | One-cycle encoder bit strobe |
| dec_strobe_o | output | 1 | One-cycle decoder bit strobe |

## Verification
The assertions take for granted that each phase of an external clock lasts at least two reference cycles, so the synchroniser never merges or drops an edge. They also take for granted that mode_i changes only between reference edges. The stimulus draws every external phase length from $urandom within two to nine cycles. It changes the mode only on the falling reference edge, always to a value different from the current one. Between changes it waits a random number of cycles, so that restarts land in the middle of periods.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic [1:0] {
    MODE_EXT   = 2'b00,
    MODE_FAST  = 2'b01,
    MODE_MID   = 2'b10,
    MODE_SLOW  = 2'b11
  } rate_mode_e;
endpackage

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_pkg::*;
#(
  parameter int unsigned DIV_FAST = 16,
  parameter int unsigned DIV_MID  = 32,
  parameter int unsigned DIV_SLOW = 64
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  output logic       gen_o,
  output logic       strobe_o
);
  localparam int unsigned HALF_MAX = DIV_SLOW / 2;
  localparam int unsigned CW       = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;

  logic [1:0]    mode_q;
  logic [CW-1:0] cnt_q, half_m1;
  logic          gen_q, stb_q;
  logic          restart, internal, wrap;

  always_comb begin
    case (mode_i)
      MODE_FAST: half_m1 = CW'(DIV_FAST / 2 - 1);
      MODE_MID:  half_m1 = CW'(DIV_MID / 2 - 1);
      MODE_SLOW: half_m1 = CW'(DIV_SLOW / 2 - 1);
      default:   half_m1 = '0;
    endcase
  end

  assign restart  = (mode_i != mode_q);
  assign internal = (mode_i != MODE_EXT);
  assign wrap     = internal && !restart && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_EXT;
      cnt_q  <= '0;
      gen_q  <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      stb_q  <= wrap && !gen_q;
      if (restart || !internal) begin
        cnt_q <= '0;
        gen_q <= 1'b0;
      end else if (wrap) begin
        cnt_q <= '0;
        gen_q <= ~gen_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign gen_o    = gen_q;
  assign strobe_o = stb_q;

  // R6
  restart_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (!gen_q && cnt_q == '0));
  // R7
  strobe_in_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |-> gen_q);
  // R7
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_q |=> !stb_q);
  // R8
  ext_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_EXT && mode_i == MODE_EXT) |-> (!gen_q && !stb_q));
endmodule

// File: rtl/sclk_edge_sync.sv
module sclk_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], async_i};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] && !sh_q[STAGES];

  // R9
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  // R9
  level_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> level_o);
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int unsigned DIV_FAST    = 16,
  parameter int unsigned DIV_MID     = 32,
  parameter int unsigned DIV_SLOW    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       enc_clk_i,
  input  logic       dec_clk_i,
  output logic       enc_clk_o,
  output logic       dec_clk_o,
  output logic       enc_clk_oe_o,
  output logic       dec_clk_oe_o,
  output logic       enc_core_clk_o,
  output logic       dec_core_clk_o,
  output logic       enc_strobe_o,
  output logic       dec_strobe_o
);
  localparam int unsigned NPORT = 2;

  logic             gen, gen_stb, ext;
  logic [NPORT-1:0] pad_in, lvl, rise, core_clk, stb;

  assign pad_in = {dec_clk_i, enc_clk_i};
  assign ext    = (mode_i == MODE_EXT);

  sclk_divider #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode_i),
    .gen_o   (gen),
    .strobe_o(gen_stb)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .async_i(pad_in[p]),
      .level_o(lvl[p]),
      .rise_o (rise[p])
    );
    assign core_clk[p] = ext ? lvl[p]  : gen;
    assign stb[p]      = ext ? rise[p] : gen_stb;
  end

  assign enc_clk_o      = gen;
  assign dec_clk_o      = gen;
  assign enc_clk_oe_o   = !ext;
  assign dec_clk_oe_o   = !ext;
  assign enc_core_clk_o = core_clk[0];
  assign dec_core_clk_o = core_clk[1];
  assign enc_strobe_o   = stb[0];
  assign dec_strobe_o   = stb[1];

  // R5
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_clk_oe_o |-> (mode_i != MODE_EXT));
  // R10
  core_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ext && enc_strobe_o) |-> enc_core_clk_o);
endmodule

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       enc_clk_i = 1'b0, dec_clk_i = 1'b0;
  logic       enc_clk_o, dec_clk_o, enc_clk_oe_o, dec_clk_oe_o;
  logic       enc_core_clk_o, dec_core_clk_o, enc_strobe_o, dec_strobe_o;

  int checks = 0;
  int failures = 0;
  logic [2:0] eh = '0, dh = '0;  // [0] newest driven value
  int erem = 3, drem = 5;

  always #5 clk_i = ~clk_i;

  sclk_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .enc_clk_i(enc_clk_i), .dec_clk_i(dec_clk_i),
    .enc_clk_o(enc_clk_o), .dec_clk_o(dec_clk_o),
    .enc_clk_oe_o(enc_clk_oe_o), .dec_clk_oe_o(dec_clk_oe_o),
    .enc_core_clk_o(enc_core_clk_o), .dec_core_clk_o(dec_core_clk_o),
    .enc_strobe_o(enc_strobe_o), .dec_strobe_o(dec_strobe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int div_of(input logic [1:0] m);
    case (m)
      2'b01:   return 16;
      2'b10:   return 32;
      2'b11:   return 64;
      default: return 0;
    endcase
  endfunction

  // drive external clocks with random phases of 2..9 cycles
  task automatic drive_in();
    logic ne, nd;
    ne = eh[0]; nd = dh[0];
    if (--erem == 0) begin ne = ~ne; erem = 2 + int'($urandom % 8); end
    if (--drem == 0) begin nd = ~nd; drem = 2 + int'($urandom % 8); end
    eh = {eh[1:0], ne};
    dh = {dh[1:0], nd};
    enc_clk_i = ne;
    dec_clk_i = nd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      drive_in();
    end
  endtask

  task automatic run_int(input logic [1:0] m);
    int div, half, q, e4, e5, e6, e7, e10, last_rise, period, hi_cnt;
    bit prev, exp_clk, exp_stb;
    div = div_of(m); half = div / 2;
    e4 = 0; e5 = 0; e6 = 0; e7 = 0; e10 = 0;
    last_rise = -1; period = 0; hi_cnt = 0; prev = 1'b0;
    mode_i = m;
    for (int j = 1; j <= 3 * div; j++) begin
      @(negedge clk_i);
      q = j - 1;
      exp_clk = (q % div) >= half;
      exp_stb = (q % div) == half;
      if (q < div && enc_clk_o !== exp_clk) e6++;
      if (enc_strobe_o !== exp_stb || dec_strobe_o !== exp_stb) e7++;
      if (enc_clk_o !== dec_clk_o) e4++;
      if (enc_clk_oe_o !== 1'b1 || dec_clk_oe_o !== 1'b1) e5++;
      if (enc_core_clk_o !== enc_clk_o || dec_core_clk_o !== dec_clk_o) e10++;
      if (q >= div) begin
        if (enc_clk_o && !prev) begin
          if (last_rise >= 0) period = q - last_rise;
          last_rise = q;
        end
        if (q < 2 * div && enc_clk_o) hi_cnt++;
      end
      prev = enc_clk_o;
      drive_in();
    end
    chk(period == div, $sformatf("R2 period mode=%0d", m), period, div);
    chk(hi_cnt == half, $sformatf("R3 high cycles mode=%0d", m), hi_cnt, half);
    chk(e4 == 0, "R4 port clocks differ", e4, 0);
    chk(e5 == 0, "R5 oe in internal mode", e5, 0);
    chk(e6 == 0, $sformatf("R6 restart phase mode=%0d", m), e6, 0);
    chk(e7 == 0, $sformatf("R7 strobe timing mode=%0d", m), e7, 0);
    chk(e10 == 0, "R10 core clock ignores pad inputs", e10, 0);
    idle(int'($urandom % div));
  endtask

  task automatic run_ext(input int n);
    int e5, e8p, e8s, e9;
    bit xe, xd;
    e5 = 0; e8p = 0; e8s = 0; e9 = 0;
    mode_i = 2'b00;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk_i);
      xe = eh[1] && !eh[2];
      xd = dh[1] && !dh[2];
      if (enc_clk_o !== 1'b0 || dec_clk_o !== 1'b0) e8p++;
      if (enc_strobe_o !== xe || dec_strobe_o !== xd) e8s++;
      if (enc_core_clk_o !== eh[1] || dec_core_clk_o !== dh[1]) e9++;
      if (enc_clk_oe_o !== 1'b0 || dec_clk_oe_o !== 1'b0) e5++;
      drive_in();
    end
    chk(e5 == 0, "R5 oe in external mode", e5, 0);
    chk(e8p == 0, "R8 pad clocks quiet", e8p, 0);
    chk(e8s == 0, "R8 external strobes", e8s, 0);
    chk(e9 == 0, "R9 synchronised core clocks", e9, 0);
  endtask

  initial begin
    logic [1:0] cur, nxt;
    void'($urandom(32'd619));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk({enc_clk_o, dec_clk_o, enc_core_clk_o, dec_core_clk_o, enc_strobe_o, dec_strobe_o} == 6'b0,
        "R1 reset outputs",
        int'({enc_clk_o, dec_clk_o, enc_core_clk_o, dec_core_clk_o, enc_strobe_o, dec_strobe_o}), 0);
    rst_ni = 1'b1;
    idle(4);
    run_ext(120);
    run_int(2'b01);
    run_int(2'b10);
    run_int(2'b11);
    run_ext(150);
    run_int(2'b11);
    run_int(2'b01);
    cur = 2'b01;
    for (int k = 0; k < 10; k++) begin
      nxt = cur + 2'(1 + ($urandom % 3));
      if (nxt == 2'b00) run_ext(80 + int'($urandom % 100));
      else              run_int(nxt);
      cur = nxt;
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule